// File: doc/BRIEF.md
# Background Built-In Test Sequencer

This block supervises a bank of angle output channels by comparing the angle each channel actually produces, as measured on its loopback path, with the angle it was told to produce. It keeps one accuracy status bit, one reference-present bit and one signal-present bit per channel, and the host reads these as three bytes. A status bit reads 1 when all is well and 0 when a fault has been seen. Channels left out of the active mask never show a fault.

Two test modes share the comparator. The scanning mode runs quietly in the background. It stays on each channel for a fixed dwell and judges that channel at the end of the dwell. It also refreshes a heartbeat byte at a fixed period, so software can clear the byte and later see that it has come back. The self-test mode is started by writing 1 to its enable bit. It takes over the output of one channel at a time through an override port and drives that channel to each of 72 evenly spaced test angles. Its enable bit drops by itself when the run completes. Writing 0 to the bit cancels the run at once. All durations are parameters counted in clock ticks.

The controller has three states: `SQ_IDLE`, `SQ_SCAN` and `SQ_SELF`. From `SQ_IDLE` it moves to `SQ_SELF` when the self-test bit is set, and otherwise to `SQ_SCAN` when scanning is enabled. From `SQ_SCAN` it moves to `SQ_SELF` when the self-test bit is set, and to `SQ_IDLE` when scanning is disabled. From `SQ_SELF` it moves to `SQ_SCAN` (if scanning is enabled) or to `SQ_IDLE` (if not) when the run completes or is cancelled.

Top module: `bist_seq`

## Requirements
- R1: After reset all three status bytes read FFh, the heartbeat byte reads 00h, and both selftest_busy and ovr_valid are 0.
- R2: While scanning, the block visits channels 0 to NCH-1 in a loop and stays SCAN_DWELL ticks on each. At the end of the dwell, an active channel's test status becomes 1 if the angle distance is within TOL (9 LSB of a 16-bit angle) and 0 if it is larger.
- R3: The angle distance is the shortest signed 16-bit difference with wraparound. For example, FFFCh against 0004h is 8 LSB and passes, while 0003h against FFF9h is 10 LSB and fails.
- R4: A channel whose active_mask bit is 0 reads 1 in all three status bytes, whatever its angles and its presence inputs are.
- R5: If the commanded angle of a channel moves by more than TOL from its value at the start of that channel's dwell, the status bit of that channel is left unchanged at the end of the dwell.
- R6: Ref or signal status of an active channel goes to 0 only after its present input has been 0 for LOSS_TICKS consecutive cycles. It returns to 1 on the cycle after the input is seen at 1.
- R7: While bg_en is 1, the heartbeat byte is loaded with 55h once every BEAT_TICKS cycles. A beat_clr pulse sets it to 00h. With bg_en at 0 nothing reloads it.
- R8: Writing 1 on the self-test write port raises selftest_busy. The run then drives ovr_valid with the angle round(k*65536/72) for k = 0..71. Within each k, ovr_chan steps through channels 0..NCH-1, and each step lasts SELF_DWELL ticks.
- R9: At the start of a self-test run every test status bit is set to 1. An active channel whose measured angle misses any of its test angles by more than TOL reads 0 when the run ends.
- R10: selftest_busy stays high for exactly 72*NCH*SELF_DWELL+1 cycles and then clears by itself. Writing 0 during a run drops selftest_busy and ovr_valid on the next cycle.
- R11: Self-test takes precedence over scanning. Once a run has begun, ovr_valid stays high until the run ends, even with bg_en at 1, and scanning resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bg_en | input | 1 | Enable for background scanning and the heartbeat |
| selftest_wr | input | 1 | Write strobe for the self-test enable bit |
| selftest_wdata | input | 1 | Value written to the self-test enable bit |
| beat_clr | input | 1 | Host clear of the heartbeat byte |
| active_mask | input | NCH | Channels that are checked |
| cmd_angle | input | NCH*16 | Commanded angles, channel c at bits [16c+15:16c] |
| meas_angle | input | NCH*16 | Measured loopback angles, same packing |
| ref_ok | input | NCH | Reference present, per channel |
| sig_ok | input | NCH | Output signal present, per channel |
| test_status | output | NCH | Accuracy status, 1 = OK |
| ref_status | output | NCH | Reference status, 1 = present |
| sig_status | output | NCH | Signal status, 1 = present |
| selftest_busy | output | 1 | Reads the self-test enable bit |
| ovr_valid | output | 1 | Test-angle override is driving a channel |
| ovr_chan | output | $clog2(NCH) | Channel under self-test |
| ovr_angle | output | 16 | Test angle to drive on ovr_chan |
| beat_byte | output | 8 | Heartbeat byte |

## Verification
If the channel pointer or the dwell counter holds a wrong value, ovr_chan skips or repeats a channel within one self-test step. In scanning mode the fault shows as a wrong status bit within two scan rounds. A broken wraparound distance or an off-by-one tolerance turns status bits at the ±9/±10 LSB boundary, including across 0/FFFFh, within two rounds. A debounce counter that is one tick off shows up on the exact LOSS_TICKS cycle. A wrong test-angle index or a wrong step length shows in the override sequence and in the busy duration, which is counted to the cycle.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int ANG_W = 16;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_SELF = 2'd2
    } sq_state_t;

    // Evenly spaced test angle k of n, rounded to nearest LSB
    function automatic logic [ANG_W-1:0] grid_angle(input int unsigned k, input int unsigned n);
        int unsigned num;
        num = k * 32'd65536 + n / 2;
        return ANG_W'(num / n);
    endfunction

endpackage

// File: rtl/bist_angle_cmp.sv
module bist_angle_cmp #(
    parameter int TOL = 9
) (
    input  logic [15:0] a,
    input  logic [15:0] b,
    output logic        near
);
    logic [15:0] diff;
    logic [16:0] mag;

    always_comb begin
        diff = a - b;
        mag  = diff[15] ? (17'h10000 - {1'b0, diff}) : {1'b0, diff};
        near = (mag <= 17'(TOL));
    end
endmodule

// File: rtl/bist_loss_filter.sv
module bist_loss_filter #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lost,
    output logic present
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !lost) begin
            run_q <= '0;
        end else if (run_q != CNT_W'(LIMIT)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign present = (run_q != CNT_W'(LIMIT));
endmodule

// File: rtl/bist_heartbeat.sv
module bist_heartbeat #(
    parameter int PERIOD = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    output logic [7:0] beat
);
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] tick_q;
    logic          wrap;

    assign wrap = en && (tick_q == PW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            beat   <= 8'h00;
        end else begin
            if (!en || wrap) tick_q <= '0;
            else             tick_q <= tick_q + 1'b1;
            if (wrap)        beat <= 8'h55;
            else if (clr)    beat <= 8'h00;
        end
    end
endmodule

// File: rtl/bist_seq.sv
module bist_seq
    import bist_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int TOL        = 9,
    parameter int NANG       = 72,
    parameter int SCAN_DWELL = 22_500_000,
    parameter int SELF_DWELL = 6_510_000,
    parameter int LOSS_TICKS = 250_000_000,
    parameter int BEAT_TICKS = 250_000_000,
    localparam int CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bg_en,
    input  logic                 selftest_wr,
    input  logic                 selftest_wdata,
    input  logic                 beat_clr,
    input  logic [NCH-1:0]       active_mask,
    input  logic [NCH*ANG_W-1:0] cmd_angle,
    input  logic [NCH*ANG_W-1:0] meas_angle,
    input  logic [NCH-1:0]       ref_ok,
    input  logic [NCH-1:0]       sig_ok,
    output logic [NCH-1:0]       test_status,
    output logic [NCH-1:0]       ref_status,
    output logic [NCH-1:0]       sig_status,
    output logic                 selftest_busy,
    output logic                 ovr_valid,
    output logic [CW-1:0]        ovr_chan,
    output logic [ANG_W-1:0]     ovr_angle,
    output logic [7:0]           beat_byte
);
    localparam int KW   = $clog2(NANG);
    localparam int DMAX = (SCAN_DWELL > SELF_DWELL) ? SCAN_DWELL : SELF_DWELL;
    localparam int DCW  = $clog2(DMAX);

    sq_state_t        state_q, state_d;
    logic             st_en_q;
    logic [DCW-1:0]   dcnt_q;
    logic [CW-1:0]    chan_q, chan_nx;
    logic [KW-1:0]    k_q;
    logic [NCH-1:0]   tst_q;
    logic [ANG_W-1:0] snap_q;
    logic             moved_q;

    logic             step_last, self_done, self_run, entering;
    logic [ANG_W-1:0] cur_cmd, cur_meas, cur_tang, ref_ang;
    logic             near_ok, steady, moved_now;

    assign cur_cmd  = cmd_angle[chan_q*ANG_W +: ANG_W];
    assign cur_meas = meas_angle[chan_q*ANG_W +: ANG_W];
    assign cur_tang = grid_angle(32'(k_q), NANG);
    assign ref_ang  = (state_q == SQ_SELF) ? cur_tang : cur_cmd;
    assign chan_nx  = (chan_q == CW'(NCH - 1)) ? '0 : chan_q + 1'b1;

    bist_angle_cmp #(.TOL(TOL)) u_acc_cmp  (.a(cur_meas), .b(ref_ang), .near(near_ok));
    bist_angle_cmp #(.TOL(TOL)) u_move_cmp (.a(cur_cmd),  .b(snap_q),  .near(steady));

    assign moved_now = moved_q || !steady;
    assign step_last = (state_q == SQ_SCAN) ? (dcnt_q == DCW'(SCAN_DWELL - 1))
                                            : (dcnt_q == DCW'(SELF_DWELL - 1));
    assign self_done = (state_q == SQ_SELF) && st_en_q && step_last &&
                       (chan_q == CW'(NCH - 1)) && (k_q == KW'(NANG - 1));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (st_en_q)    state_d = SQ_SELF;
                else if (bg_en) state_d = SQ_SCAN;
            end
            SQ_SCAN: begin
                if (st_en_q)     state_d = SQ_SELF;
                else if (!bg_en) state_d = SQ_IDLE;
            end
            SQ_SELF: begin
                if (!st_en_q || self_done) state_d = bg_en ? SQ_SCAN : SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end
    assign entering = (state_d != state_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        self_run      = (state_q == SQ_SELF) && st_en_q;
        ovr_valid     = self_run;
        ovr_chan      = chan_q;
        ovr_angle     = self_run ? cur_tang : '0;
        selftest_busy = st_en_q;
    end

    // Self-test enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)           st_en_q <= 1'b0;
        else if (self_done)   st_en_q <= 1'b0;
        else if (selftest_wr) st_en_q <= selftest_wdata;
    end

    // Sequencing datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt_q  <= '0;
            chan_q  <= '0;
            k_q     <= '0;
            tst_q   <= '1;
            snap_q  <= '0;
            moved_q <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_SCAN: begin
                    if (dcnt_q == '0) begin
                        snap_q  <= cur_cmd;
                        moved_q <= 1'b0;
                    end else begin
                        moved_q <= moved_now;
                    end
                    if (step_last) begin
                        dcnt_q <= '0;
                        chan_q <= chan_nx;
                        if (active_mask[chan_q] && !moved_now)
                            tst_q[chan_q] <= near_ok;
                    end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                    end
                end
                SQ_SELF: begin
                    if (st_en_q) begin
                        if (step_last) begin
                            dcnt_q <= '0;
                            chan_q <= chan_nx;
                            if (chan_q == CW'(NCH - 1)) k_q <= k_q + 1'b1;
                            if (active_mask[chan_q] && !near_ok)
                                tst_q[chan_q] <= 1'b0;
                        end else begin
                            dcnt_q <= dcnt_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if (entering) begin
                dcnt_q <= '0;
                if (state_d == SQ_SELF) begin
                    chan_q <= '0;
                    k_q    <= '0;
                    tst_q  <= '1;
                end
            end
        end
    end

    assign test_status = tst_q | ~active_mask;

    // Presence debounce per channel
    for (genvar c = 0; c < NCH; c++) begin : g_loss
        bist_loss_filter #(.LIMIT(LOSS_TICKS)) u_ref (
            .clk(clk), .rst_n(rst_n),
            .lost(!ref_ok[c] && active_mask[c]), .present(ref_status[c]));
        bist_loss_filter #(.LIMIT(LOSS_TICKS)) u_sig (
            .clk(clk), .rst_n(rst_n),
            .lost(!sig_ok[c] && active_mask[c]), .present(sig_status[c]));
    end

    bist_heartbeat #(.PERIOD(BEAT_TICKS)) u_beat (
        .clk(clk), .rst_n(rst_n), .en(bg_en), .clr(beat_clr), .beat(beat_byte));

endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bg_en,
    input logic           selftest_wr,
    input logic           selftest_wdata,
    input logic           beat_clr,
    input logic [NCH-1:0] active_mask,
    input logic [NCH-1:0] ref_ok,
    input logic [NCH-1:0] sig_ok,
    input logic [NCH-1:0] ref_status,
    input logic [NCH-1:0] sig_status,
    input logic           selftest_busy,
    input logic           ovr_valid,
    input logic [CW-1:0]  ovr_chan,
    input logic [7:0]     beat_byte
);
    // R10
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_wr && !selftest_wdata |=> !selftest_busy && !ovr_valid);

    // R8
    ovr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> selftest_busy);

    // R8
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid && $past(ovr_valid) && (ovr_chan != $past(ovr_chan)) |->
        ovr_chan == (($past(ovr_chan) == CW'(NCH - 1)) ? '0 : $past(ovr_chan) + 1'b1));

    // R7
    beat_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_byte == 8'h00 || beat_byte == 8'h55);

    // R7
    beat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_clr && !bg_en |=> beat_byte == 8'h00);

    // R6
    ref_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (~ref_status & ($past(ref_ok) | ~$past(active_mask))) == '0);

    // R6
    sig_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (~sig_status & ($past(sig_ok) | ~$past(active_mask))) == '0);
endmodule

bind bist_seq bist_seq_chk #(.NCH(NCH), .CW(CW)) u_bist_chk (
    .clk(clk), .rst_n(rst_n), .bg_en(bg_en),
    .selftest_wr(selftest_wr), .selftest_wdata(selftest_wdata),
    .beat_clr(beat_clr), .active_mask(active_mask),
    .ref_ok(ref_ok), .sig_ok(sig_ok),
    .ref_status(ref_status), .sig_status(sig_status),
    .selftest_busy(selftest_busy), .ovr_valid(ovr_valid),
    .ovr_chan(ovr_chan), .beat_byte(beat_byte));

// File: tb/tb_bist_seq.sv
module tb_bist_seq;
    localparam int NCH   = 8;
    localparam int SDW   = 8;
    localparam int FDW   = 4;
    localparam int LOSS  = 20;
    localparam int BEAT  = 50;
    localparam int ROUND = NCH * SDW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bg_en = 1'b0, selftest_wr = 1'b0, selftest_wdata = 1'b0, beat_clr = 1'b0;
    logic [NCH-1:0] active_mask = '1, ref_ok = '1, sig_ok = '1;
    logic [NCH*16-1:0] cmd_flat, meas_flat;
    logic [NCH-1:0] test_status, ref_status, sig_status;
    logic selftest_busy, ovr_valid;
    logic [2:0] ovr_chan;
    logic [15:0] ovr_angle;
    logic [7:0] beat_byte;

    logic [15:0] cmd_v [NCH];
    logic [15:0] err_v [NCH];
    logic [15:0] bias  [NCH];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            cmd_flat[c*16 +: 16] = cmd_v[c];
            if (ovr_valid && ovr_chan == 3'(c))
                meas_flat[c*16 +: 16] = ovr_angle + bias[c];
            else
                meas_flat[c*16 +: 16] = cmd_v[c] + err_v[c];
        end
    end

    bist_seq #(.NCH(NCH), .TOL(9), .NANG(72), .SCAN_DWELL(SDW), .SELF_DWELL(FDW),
               .LOSS_TICKS(LOSS), .BEAT_TICKS(BEAT)) dut (
        .clk(clk), .rst_n(rst_n), .bg_en(bg_en),
        .selftest_wr(selftest_wr), .selftest_wdata(selftest_wdata),
        .beat_clr(beat_clr), .active_mask(active_mask),
        .cmd_angle(cmd_flat), .meas_angle(meas_flat),
        .ref_ok(ref_ok), .sig_ok(sig_ok),
        .test_status(test_status), .ref_status(ref_status), .sig_status(sig_status),
        .selftest_busy(selftest_busy), .ovr_valid(ovr_valid),
        .ovr_chan(ovr_chan), .ovr_angle(ovr_angle), .beat_byte(beat_byte));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            cmd_v[c] = 16'(c * 4000);
            err_v[c] = '0;
            bias[c]  = '0;
        end
        wait_neg(5);
        rst_n = 1'b1;
        wait_neg(1);
        // R1 reset state
        check("R1 test_status", 32'(test_status), 32'hFF);
        check("R1 ref_status", 32'(ref_status), 32'hFF);
        check("R1 sig_status", 32'(sig_status), 32'hFF);
        check("R1 beat", 32'(beat_byte), 32'h00);
        check("R1 busy/ovr", {30'd0, selftest_busy, ovr_valid}, 32'd0);

        // R2 sweep of error around the tolerance edge
        bg_en = 1'b1;
        for (int e = -12; e <= 12; e++) begin
            for (int c = 0; c < NCH; c++) begin
                cmd_v[c] = 16'(c * 9363 + (e + 12) * 4099);
                err_v[c] = 16'(e);
            end
            wait_neg(2 * ROUND + 2);
            check("R2 sweep", 32'(test_status), (e >= -9 && e <= 9) ? 32'hFF : 32'h00);
        end

        // R3 wraparound distances
        for (int c = 0; c < NCH; c++) err_v[c] = '0;
        cmd_v[0] = 16'hFFFC; err_v[0] = 16'd8;
        cmd_v[1] = 16'h0003; err_v[1] = -16'sd10;
        cmd_v[2] = 16'hFFFA; err_v[2] = 16'd10;
        wait_neg(2 * ROUND + 2);
        check("R3 wrap", 32'(test_status), 32'hF9);

        // R4 inactive channels never fault
        active_mask = 8'h0F;
        for (int c = 0; c < NCH; c++) err_v[c] = 16'd50;
        ref_ok = '0; sig_ok = '0;
        wait_neg(2 * ROUND + 2);
        check("R4 test", 32'(test_status), 32'hF0);
        check("R4 ref", 32'(ref_status), 32'hF0);
        check("R4 sig", 32'(sig_status), 32'hF0);
        active_mask = '1; ref_ok = '1; sig_ok = '1;
        for (int c = 0; c < NCH; c++) err_v[c] = '0;
        wait_neg(2 * ROUND + 2);
        check("R4 restore", 32'(test_status), 32'hFF);

        // R5 moving command masks the error
        err_v[3] = 16'd500;
        for (int i = 0; i < 3 * ROUND; i++) begin
            cmd_v[3] = cmd_v[3] + ((i % 2 == 0) ? 16'd100 : -16'sd100);
            @(negedge clk);
        end
        check("R5 moving", 32'(test_status[3]), 32'd1);
        wait_neg(2 * ROUND + 2);
        check("R5 settled", 32'(test_status[3]), 32'd0);
        err_v[3] = '0;
        wait_neg(2 * ROUND + 2);

        // R6 debounce boundary
        sig_ok[1] = 1'b0;
        wait_neg(LOSS - 1);
        check("R6 before limit", 32'(sig_status[1]), 32'd1);
        wait_neg(1);
        check("R6 at limit", 32'(sig_status[1]), 32'd0);
        sig_ok[1] = 1'b1;
        wait_neg(1);
        check("R6 recover", 32'(sig_status[1]), 32'd1);
        ref_ok[4] = 1'b0; wait_neg(LOSS - 1);
        ref_ok[4] = 1'b1; wait_neg(1);
        ref_ok[4] = 1'b0; wait_neg(LOSS - 1);
        check("R6 not consecutive", 32'(ref_status[4]), 32'd1);
        ref_ok[4] = 1'b1; wait_neg(1);

        // R7 heartbeat
        bg_en = 1'b0;
        beat_clr = 1'b1; wait_neg(1); beat_clr = 1'b0;
        check("R7 cleared", 32'(beat_byte), 32'h00);
        wait_neg(3 * BEAT);
        check("R7 idle no reload", 32'(beat_byte), 32'h00);
        bg_en = 1'b1;
        wait_neg(BEAT + 2);
        check("R7 reload", 32'(beat_byte), 32'h55);
        bg_en = 1'b0;
        wait_neg(2);

        // R8/R9/R10 full self-test run
        active_mask = 8'hBF;
        bias[2] = 16'd9; bias[5] = 16'd10; bias[6] = 16'd300;
        selftest_wr = 1'b1; selftest_wdata = 1'b1;
        wait_neg(1);
        selftest_wr = 1'b0;
        begin
            int busy_cnt = 0, steps = 0, gaps = 0;
            int last_chan = -1;
            while (selftest_busy) begin
                busy_cnt++;
                if (!ovr_valid) gaps++;
                else if (int'(ovr_chan) != last_chan) begin
                    check("R8 chan", 32'(ovr_chan), 32'(steps % NCH));
                    check("R8 angle", 32'(ovr_angle),
                          32'(((steps / NCH) * 65536 + 36) / 72));
                    last_chan = int'(ovr_chan);
                    steps++;
                end
                @(negedge clk);
            end
            check("R10 busy length", 32'(busy_cnt), 32'(72 * NCH * FDW + 1));
            check("R8 step count", 32'(steps), 32'(72 * NCH));
            check("R11 override held", 32'(gaps), 32'd1);
        end
        check("R9 result", 32'(test_status), 32'hDF);
        check("R10 ovr off", 32'(ovr_valid), 32'd0);

        // R10/R11 abort with scanning enabled
        bg_en = 1'b1;
        selftest_wr = 1'b1; selftest_wdata = 1'b1;
        wait_neg(1);
        selftest_wr = 1'b0;
        wait_neg(100);
        check("R11 override during scan", {30'd0, selftest_busy, ovr_valid}, 32'd3);
        selftest_wr = 1'b1; selftest_wdata = 1'b0;
        wait_neg(1);
        selftest_wr = 1'b0;
        check("R10 abort", {30'd0, selftest_busy, ovr_valid}, 32'd0);
        wait_neg(2 * ROUND + 4);
        check("R11 scan resumes", 32'(test_status), 32'hFF);

        summary();
        $finish;
    end
endmodule